// File: doc/BRIEF.md
# Elastic Three-Stage Queue-Coupled Pipeline

This block runs a 16-bit word through three fixed combinational transforms. The stages are not tied together by one global advance signal. Each adjacent pair of stages is joined by a small queue. A stage moves a word whenever the queue in front of it holds data and the queue behind it can accept a word. No per-word valid flag travels with the data, because queue occupancy alone says where the live words are. Both ends of the block are queues with valid/ready handshakes.

The stage functions are applied in order:

- first: add 3, modulo 2^WIDTH;
- second: rotate left by one bit;
- third: XOR with a mask that has every odd-numbered bit set (0xAAAA at 16 bits).

The parameter `MID_MODE` sets how the two inner queues behave:

- `FIFO_PASS`: a dequeue frees the slot for an enqueue in the same cycle, even when the queue is full, so all three stages can advance together.
- `FIFO_PLAIN`: a queue never enqueues and dequeues in one cycle. This mode exists to show the loss of throughput.

The boundary queues always use pass behaviour.

Top module: `epipe_top`

## Requirements
- R1: Every output word equals third(second(first(x))) for its input word x, using the three stage functions given above.
- R2: Words leave in the same order in which they were accepted, with none lost and none duplicated.
- R3: A stage moves a word only when its upstream queue is non-empty and its downstream queue accepts. With out_ready held low, the block accepts exactly 4 × DEPTH words (8 with the defaults) and then deasserts in_ready.
- R4: In FIFO_PASS mode, a continuous input stream with out_ready held high yields one result per clock. 32 words give 31 cycles from the first output transfer to the last.
- R5: In FIFO_PLAIN mode, no inner queue enqueues and dequeues in the same cycle. The same 32-word stream yields one result every two cycles, 62 cycles from the first output transfer to the last.
- R6: With the pipeline empty and out_ready high, a word accepted on one rising edge is handed out on the fourth rising edge after it.
- R7: After reset, out_valid is low and in_ready is high.
- R8: While out_valid is high and out_ready is low, out_valid stays high and out_data holds its value.
- R9: In FIFO_PASS mode, when every queue is full and out_ready rises, the block transfers one word in and one word out on every cycle. No bubble appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Source offers a word |
| in_ready | output | 1 | Input queue accepts a word |
| in_data | input | WIDTH | Input word |
| out_valid | output | 1 | Output queue holds a result |
| out_ready | input | 1 | Sink takes the result |
| out_data | output | WIDTH | Result word |

## Verification
The key overlap is a dequeue and an enqueue on the same queue in one cycle. This happens when a stage and its downstream neighbour both advance.

In pass mode, the bench provokes the overlap in two ways:

- It streams words with the sink always ready, and requires output transfers on consecutive edges.
- It fills every queue with the sink stalled, then releases the sink. It requires 16 consecutive transfers with no gap.

In plain mode, the same stream must show exactly two cycles per result. Random sink stalls and source gaps on both variants check order and values through the scoreboard.

// File: rtl/epipe_pkg.sv
package epipe_pkg;

   typedef enum logic {
      FIFO_PASS  = 1'b0,
      FIFO_PLAIN = 1'b1
   } fifo_mode_e;

   localparam int unsigned NUM_STAGES = 3;
   localparam int unsigned NUM_QUEUES = NUM_STAGES + 1;

endpackage

// File: rtl/epipe_fifo.sv
module epipe_fifo
   import epipe_pkg::*;
#(
   parameter int unsigned WIDTH = 16,
   parameter int unsigned DEPTH = 2,
   parameter fifo_mode_e  MODE  = FIFO_PASS
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enq_valid,
   output logic             enq_ready,
   input  logic [WIDTH-1:0] enq_data,
   output logic             deq_valid,
   input  logic             deq_ready,
   output logic [WIDTH-1:0] deq_data
);

   localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int unsigned CW = $clog2(DEPTH + 1);
   localparam logic [AW-1:0] LAST_SLOT = AW'(DEPTH - 1);
   localparam logic [CW-1:0] FULL_CNT  = CW'(DEPTH);

   if (DEPTH < 1) begin : g_bad_depth
      $error("epipe_fifo: DEPTH must be at least 1");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("epipe_fifo: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] slots [DEPTH];
   logic [AW-1:0]    rd_ptr;
   logic [AW-1:0]    wr_ptr;
   logic [CW-1:0]    count;
   logic             is_full;
   logic             enq_fire;
   logic             deq_fire;

   assign is_full   = (count == FULL_CNT);
   assign deq_valid = (count != '0);
   assign deq_data  = slots[rd_ptr];
   assign deq_fire  = deq_valid && deq_ready;
   assign enq_fire  = enq_valid && enq_ready;

   if (MODE == FIFO_PASS) begin : g_pass
      // a departing head frees its slot for this cycle's arrival
      assign enq_ready = !is_full || deq_ready;
   end else begin : g_plain
      // one operation per cycle; the read side wins
      assign enq_ready = !is_full && !deq_fire;
   end

   function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
      return (p == LAST_SLOT) ? '0 : p + AW'(1);
   endfunction

   always_ff @(posedge clk) begin
      if (enq_fire) begin
         slots[wr_ptr] <= enq_data;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         count  <= '0;
      end else begin
         if (enq_fire) begin
            wr_ptr <= bump(wr_ptr);
         end
         if (deq_fire) begin
            rd_ptr <= bump(rd_ptr);
         end
         case ({enq_fire, deq_fire})
            2'b10:   count <= count + CW'(1);
            2'b01:   count <= count - CW'(1);
            default: count <= count;
         endcase
      end
   end

   AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      count <= FULL_CNT); // R3

   AST_HEAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      deq_valid && !deq_ready |=> deq_valid && $stable(deq_data)); // R8

   if (MODE == FIFO_PLAIN) begin : g_plain_chk
      AST_NO_DUAL_OP: assert property (@(posedge clk) disable iff (!rst_n)
         !(enq_fire && deq_fire)); // R5
   end else begin : g_pass_chk
      AST_FULL_PASS: assert property (@(posedge clk) disable iff (!rst_n)
         is_full && deq_fire && enq_valid |=> is_full); // R9
   end

endmodule

// File: rtl/epipe_stage.sv
module epipe_stage #(
   parameter int unsigned WIDTH = 16,
   parameter int unsigned STAGE = 0
) (
   input  logic             in_valid,
   output logic             in_ready,
   input  logic [WIDTH-1:0] in_data,
   output logic             out_valid,
   input  logic             out_ready,
   output logic [WIDTH-1:0] out_data
);

   if (STAGE > 2) begin : g_bad_stage
      $error("epipe_stage: STAGE selects one of three functions");
   end
   if (WIDTH < 2) begin : g_bad_width
      $error("epipe_stage: WIDTH must be at least 2");
   end

   function automatic logic [WIDTH-1:0] odd_mask();
      logic [WIDTH-1:0] m;
      for (int i = 0; i < int'(WIDTH); i++) begin
         m[i] = (i % 2) == 1;
      end
      return m;
   endfunction

   localparam logic [WIDTH-1:0] ODD_BITS = odd_mask();
   localparam logic [WIDTH-1:0] OFFSET   = WIDTH'(3);

   // firing: upstream holds a word and downstream takes it
   assign out_valid = in_valid;
   assign in_ready  = out_ready;

   if (STAGE == 0) begin : g_add
      assign out_data = in_data + OFFSET;
   end else if (STAGE == 1) begin : g_rot
      assign out_data = {in_data[WIDTH-2:0], in_data[WIDTH-1]};
   end else begin : g_mix
      assign out_data = in_data ^ ODD_BITS;
   end

endmodule

// File: rtl/epipe_top.sv
module epipe_top
   import epipe_pkg::*;
#(
   parameter int unsigned WIDTH      = 16,
   parameter int unsigned MID_DEPTH  = 2,
   parameter int unsigned EDGE_DEPTH = 2,
   parameter fifo_mode_e  MID_MODE   = FIFO_PASS
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic [WIDTH-1:0] in_data,
   output logic             out_valid,
   input  logic             out_ready,
   output logic [WIDTH-1:0] out_data
);

   if (MID_DEPTH < 1 || EDGE_DEPTH < 1) begin : g_bad_depth
      $error("epipe_top: queue depths must be at least 1");
   end

   logic             q_enq_v [NUM_QUEUES];
   logic             q_enq_r [NUM_QUEUES];
   logic [WIDTH-1:0] q_enq_d [NUM_QUEUES];
   logic             q_deq_v [NUM_QUEUES];
   logic             q_deq_r [NUM_QUEUES];
   logic [WIDTH-1:0] q_deq_d [NUM_QUEUES];

   assign q_enq_v[0] = in_valid;
   assign q_enq_d[0] = in_data;
   assign in_ready   = q_enq_r[0];

   assign out_valid                = q_deq_v[NUM_QUEUES-1];
   assign out_data                 = q_deq_d[NUM_QUEUES-1];
   assign q_deq_r[NUM_QUEUES-1]    = out_ready;

   for (genvar k = 0; k < NUM_QUEUES; k++) begin : g_q
      localparam bit IS_EDGE = (k == 0) || (k == NUM_QUEUES - 1);
      localparam fifo_mode_e QMODE = IS_EDGE ? FIFO_PASS : MID_MODE;
      localparam int unsigned QDEPTH = IS_EDGE ? EDGE_DEPTH : MID_DEPTH;

      epipe_fifo #(
         .WIDTH (WIDTH),
         .DEPTH (QDEPTH),
         .MODE  (QMODE)
      ) u_fifo (
         .clk       (clk),
         .rst_n     (rst_n),
         .enq_valid (q_enq_v[k]),
         .enq_ready (q_enq_r[k]),
         .enq_data  (q_enq_d[k]),
         .deq_valid (q_deq_v[k]),
         .deq_ready (q_deq_r[k]),
         .deq_data  (q_deq_d[k])
      );
   end

   for (genvar s = 0; s < NUM_STAGES; s++) begin : g_st
      epipe_stage #(
         .WIDTH (WIDTH),
         .STAGE (s)
      ) u_stage (
         .in_valid  (q_deq_v[s]),
         .in_ready  (q_deq_r[s]),
         .in_data   (q_deq_d[s]),
         .out_valid (q_enq_v[s+1]),
         .out_ready (q_enq_r[s+1]),
         .out_data  (q_enq_d[s+1])
      );

      AST_STAGE_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
         (q_enq_v[s+1] && q_enq_r[s+1]) == (q_deq_v[s] && q_deq_r[s])); // R3
   end

   AST_IDLE_AFTER_RESET: assert property (@(posedge clk)
      !rst_n |=> !out_valid && in_ready); // R7

endmodule

// File: tb/tb_epipe_top.sv
`timescale 1ns/1ps
module tb_epipe_top;
   import epipe_pkg::*;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic        a_in_valid = 1'b0, a_out_ready = 1'b0;
   logic [15:0] a_in_data = '0;
   logic        a_in_ready, a_out_valid;
   logic [15:0] a_out_data;
   logic        b_in_valid = 1'b0, b_out_ready = 1'b0;
   logic [15:0] b_in_data = '0;
   logic        b_in_ready, b_out_valid;
   logic [15:0] b_out_data;

   epipe_top #(.WIDTH(16), .MID_DEPTH(2), .EDGE_DEPTH(2), .MID_MODE(FIFO_PASS)) dut (
      .clk(clk), .rst_n(rst_n),
      .in_valid(a_in_valid), .in_ready(a_in_ready), .in_data(a_in_data),
      .out_valid(a_out_valid), .out_ready(a_out_ready), .out_data(a_out_data));

   epipe_top #(.WIDTH(16), .MID_DEPTH(2), .EDGE_DEPTH(2), .MID_MODE(FIFO_PLAIN)) dut_conv (
      .clk(clk), .rst_n(rst_n),
      .in_valid(b_in_valid), .in_ready(b_in_ready), .in_data(b_in_data),
      .out_valid(b_out_valid), .out_ready(b_out_ready), .out_data(b_out_data));

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit done = 1'b0;
   logic [15:0] exp_a [$];
   logic [15:0] exp_b [$];
   int edges_a [$];
   int edges_b [$];
   int in_edge_a, in_edge_b;

   always @(posedge clk) cyc <= cyc + 1;

   function automatic logic [15:0] model(input logic [15:0] x);
      logic [15:0] y;
      y = x + 16'd3;
      y = {y[14:0], y[15]};
      return y ^ 16'hAAAA;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   // drivers: called right after a falling edge
   task automatic send_a(input logic [15:0] v);
      a_in_valid = 1'b1; a_in_data = v; #1;
      while (!a_in_ready) begin @(negedge clk); #1; end
      exp_a.push_back(model(v)); in_edge_a = cyc + 1;
      @(negedge clk); a_in_valid = 1'b0;
   endtask

   task automatic send_b(input logic [15:0] v);
      b_in_valid = 1'b1; b_in_data = v; #1;
      while (!b_in_ready) begin @(negedge clk); #1; end
      exp_b.push_back(model(v)); in_edge_b = cyc + 1;
      @(negedge clk); b_in_valid = 1'b0;
   endtask

   // monitors: scoreboard compare for R1 and R2
   initial forever begin
      @(negedge clk); #1;
      if (rst_n && a_out_valid && a_out_ready) begin
         edges_a.push_back(cyc + 1);
         if (exp_a.size() == 0) check(1'b0, "R2 pass extra word", int'(a_out_data), -1);
         else begin
            logic [15:0] e;
            e = exp_a.pop_front();
            check(a_out_data == e, "R1/R2 pass data", int'(a_out_data), int'(e));
         end
      end
      if (rst_n && b_out_valid && b_out_ready) begin
         edges_b.push_back(cyc + 1);
         if (exp_b.size() == 0) check(1'b0, "R2 plain extra word", int'(b_out_data), -1);
         else begin
            logic [15:0] e;
            e = exp_b.pop_front();
            check(b_out_data == e, "R1/R2 plain data", int'(b_out_data), int'(e));
         end
      end
   end

   initial begin
      repeat (30000) @(posedge clk);
      check(1'b0, "watchdog", cyc, 0);
      finish_run();
   end

   bit stall_on;

   initial begin
      int n;
      int held_cnt;
      logic [15:0] held;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #1;
      check(!a_out_valid && a_in_ready, "R7 pass idle", int'({a_out_valid, a_in_ready}), 1);
      check(!b_out_valid && b_in_ready, "R7 plain idle", int'({b_out_valid, b_in_ready}), 1);

      // R6: latency through an empty pipeline
      @(negedge clk);
      a_out_ready = 1'b1; b_out_ready = 1'b1;
      fork
         send_a(16'h1234);
         send_b(16'h00FF);
      join
      repeat (8) @(negedge clk);
      check(edges_a.size() == 1 && edges_a[0] - in_edge_a == 4, "R6 pass latency",
            edges_a.size() ? edges_a[0] - in_edge_a : -1, 4);
      check(edges_b.size() == 1 && edges_b[0] - in_edge_b == 4, "R6 plain latency",
            edges_b.size() ? edges_b[0] - in_edge_b : -1, 4);

      // R4 / R5: steady stream, sink always ready
      edges_a.delete(); edges_b.delete();
      fork
         for (int i = 0; i < 32; i++) send_a(16'(i * 77 + 5));
         for (int i = 0; i < 32; i++) send_b(16'(i * 91 + 2));
      join
      repeat (80) @(negedge clk);
      check(edges_a.size() == 32, "R4 pass count", edges_a.size(), 32);
      check(edges_a.size() == 32 && edges_a[31] - edges_a[0] == 31, "R4 pass one per cycle",
            edges_a.size() ? edges_a[$] - edges_a[0] : -1, 31);
      check(edges_b.size() == 32, "R5 plain count", edges_b.size(), 32);
      check(edges_b.size() == 32 && edges_b[31] - edges_b[0] == 62, "R5 plain one per two cycles",
            edges_b.size() ? edges_b[$] - edges_b[0] : -1, 62);

      // R3 / R8: fill with sink stalled
      a_out_ready = 1'b0;
      @(negedge clk);
      n = 0;
      a_in_valid = 1'b1;
      for (int i = 0; i < 16; i++) begin
         a_in_data = 16'(16'h0100 + n); #1;
         if (a_in_ready) begin exp_a.push_back(model(a_in_data)); n++; end
         @(negedge clk);
      end
      a_in_valid = 1'b0;
      check(n == 8, "R3 capacity while stalled", n, 8);
      #1;
      held = a_out_data;
      held_cnt = 0;
      for (int i = 0; i < 5; i++) begin
         @(negedge clk); #1;
         if (a_out_valid && a_out_data == held) held_cnt++;
      end
      check(held_cnt == 5, "R8 head held under stall", held_cnt, 5);

      // R9: release a full pipeline while still feeding
      @(negedge clk);
      edges_a.delete();
      a_out_ready = 1'b1;
      for (int i = 0; i < 8; i++) send_a(16'(16'h0200 + i));
      repeat (12) @(negedge clk);
      check(edges_a.size() == 16, "R9 drain count", edges_a.size(), 16);
      check(edges_a.size() == 16 && edges_a[15] - edges_a[0] == 15, "R9 no bubble",
            edges_a.size() ? edges_a[$] - edges_a[0] : -1, 15);

      // R2 / R3: random stalls and gaps on both variants
      stall_on = 1'b1;
      fork
         begin
            while (stall_on) begin
               a_out_ready = ($urandom % 3) != 0;
               b_out_ready = ($urandom % 2) != 0;
               @(negedge clk);
            end
         end
         begin
            fork
               for (int i = 0; i < 60; i++) begin
                  repeat ($urandom % 3) @(negedge clk);
                  send_a(16'($urandom));
               end
               for (int i = 0; i < 60; i++) begin
                  repeat ($urandom % 3) @(negedge clk);
                  send_b(16'($urandom));
               end
            join
            stall_on = 1'b0;
         end
      join
      a_out_ready = 1'b1; b_out_ready = 1'b1;
      repeat (30) @(negedge clk);
      check(exp_a.size() == 0, "R2 pass all delivered", exp_a.size(), 0);
      check(exp_b.size() == 0, "R2 plain all delivered", exp_b.size(), 0);
      finish_run();
   end

endmodule